// File: doc/BRIEF.md
# MII Receive Nibble Frame Assembler

This block sits on the receive side of a 4-bit media-independent interface. On every rising edge of the receive clock that the physical-layer device supplies (25 MHz at 100 Mb/s, 2.5 MHz at 10 Mb/s), it samples a data nibble, a data-valid flag and a receive-error flag. It looks for the preamble and the start-of-frame delimiter. It then pairs the payload nibbles into bytes and sends them out as a byte stream, with a marker on the first byte of each frame.

When data-valid falls, the block closes the frame. It raises a one-cycle end-of-frame strobe and updates a status word. The status word holds the number of bytes delivered, a sticky receive-error flag and a flag for a trailing unpaired nibble. A receive error does not cut the frame short. Every byte is still delivered, and the error shows up only in the status. CRC checking, address filtering and host buffering belong to the blocks downstream.

Top module: `mii_rx_assembler`

## Requirements
- R1: A nibble is taken only in a cycle where `rx_dv` is 1, with `rxd[0]` as its least significant bit. Within each payload byte, the first nibble received becomes bits 3:0 and the second becomes bits 7:4. The byte appears on `byte_data` with `byte_valid` high for one cycle, starting in the cycle after the second nibble is sampled.
- R2: Nibbles of value 0x5 at the start of a frame are preamble and are discarded. A nibble 0xD that follows at least one 0x5 ends the delimiter, and every later nibble up to the fall of `rx_dv` is payload.
- R3: A frame is discarded with no byte and no end-of-frame strobe in two cases: a nibble other than 0x5 or 0xD arrives before the delimiter, or the first nibble is not 0x5. The status outputs stay unchanged.
- R4: `sof` is 1 together with `byte_valid` on the first payload byte of a frame, and 0 on every other byte.
- R5: After a delimited frame, the cycle in which `rx_dv` is first sampled 0 makes `eof` high for exactly one cycle, starting in the next cycle. `eof` is never high in the same cycle as `byte_valid`.
- R6: On `eof`, `stat_len` gives the number of payload bytes delivered in that frame.
- R7: If `rx_er` is 1 in any cycle where `rx_dv` is 1, from the first nibble of the frame (preamble included) to its last, then `stat_err` is 1 at that frame's end. All payload bytes are still delivered. `rx_er` has no effect while `rx_dv` is 0.
- R8: The error flag clears when the next frame starts, so a later frame without errors reports `stat_err` = 0.
- R9: An odd number of payload nibbles sets `stat_dribble` to 1 at frame end, and the unpaired last nibble produces no byte. An even number gives 0.
- R10: `stat_len` saturates at 2^LEN_W-1 (2047 by default) for longer frames.
- R11: `stat_len`, `stat_err` and `stat_dribble` change only in the cycle where `eof` is 1, and hold their values between frames.
- R12: While `rst_n` is 0, `byte_valid`, `sof` and `eof` are 0, and so are all status fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the physical-layer device |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error indication |
| rxd | input | 4 | Receive data nibble, bit 0 least significant |
| byte_valid | output | 1 | One-cycle strobe for an assembled payload byte |
| byte_data | output | 8 | Assembled payload byte |
| sof | output | 1 | First payload byte of the frame |
| eof | output | 1 | One-cycle end-of-frame strobe |
| stat_len | output | LEN_W | Payload byte count of the last frame, saturating |
| stat_err | output | 1 | Receive error seen during the last frame |
| stat_dribble | output | 1 | Last frame ended with an unpaired nibble |

## Verification
The hardest case to reach from the ports is the length counter at its saturation limit. Only a frame of more than 2047 payload bytes gets there, and the 2050-byte frame does so. The bench drives its payload nibbles one by one and checks every byte on the way, along with the clamped count at the end. Error placement is also awkward to reach. For that reason each table row carries the index of the nibble that raises `rx_er`, so errors land in the preamble, in the payload and between frames, where `rx_dv` is low. A row with no error follows the errored rows to show that the flag clears. Malformed preambles are written as explicit nibble sequences.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2,
    ST_DISC = 2'd3
  } rx_state_e;

  localparam logic [3:0] NIB_PREAMBLE = 4'h5;
  localparam logic [3:0] NIB_DELIM    = 4'hD;

  // first nibble on the wire is the low half
  function automatic logic [7:0] join_nibbles(input logic [3:0] first_nib,
                                              input logic [3:0] second_nib);
    return {second_nib, first_nib};
  endfunction

  // successor while searching for the delimiter, data-valid high
  function automatic rx_state_e hunt_next(input rx_state_e cur,
                                          input logic [3:0] nib);
    rx_state_e nxt;
    nxt = ST_DISC;
    if (nib == NIB_PREAMBLE)
      nxt = ST_HUNT;
    else if (cur == ST_HUNT && nib == NIB_DELIM)
      nxt = ST_DATA;
    return nxt;
  endfunction

endpackage

// File: rtl/mii_rx_delimiter.sv
module mii_rx_delimiter
  import mii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_dv,
  input  logic [3:0] rxd,
  output logic       frame_start,
  output logic       sfd_hit,
  output logic       data_nib,
  output logic       frame_end
);

  rx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (rx_dv) state_d = hunt_next(ST_IDLE, rxd);
      ST_HUNT: state_d = rx_dv ? hunt_next(ST_HUNT, rxd) : ST_IDLE;
      ST_DATA: if (!rx_dv) state_d = ST_IDLE;
      ST_DISC: if (!rx_dv) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign frame_start = rx_dv && (state_q == ST_IDLE);
  assign sfd_hit     = rx_dv && (state_q == ST_HUNT) && (rxd == NIB_DELIM);
  assign data_nib    = rx_dv && (state_q == ST_DATA);
  assign frame_end   = !rx_dv && (state_q == ST_DATA);

endmodule

// File: rtl/mii_rx_pairer.sv
module mii_rx_pairer
  import mii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sfd_hit,
  input  logic       data_nib,
  input  logic [3:0] rxd,
  output logic       byte_done,
  output logic       odd_pending,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       sof
);

  logic       phase_q;
  logic [3:0] low_q;
  logic       first_q;

  assign byte_done   = data_nib && phase_q;
  assign odd_pending = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= 1'b0;
      low_q      <= '0;
      first_q    <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      sof        <= 1'b0;
    end else begin
      byte_valid <= byte_done;
      sof        <= byte_done && first_q;
      if (byte_done)
        byte_data <= join_nibbles(low_q, rxd);
      if (sfd_hit) begin
        phase_q <= 1'b0;
        first_q <= 1'b1;
      end else if (data_nib) begin
        phase_q <= !phase_q;
        if (!phase_q) low_q <= rxd;
        if (phase_q) first_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mii_rx_status.sv
module mii_rx_status #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_dv,
  input  logic             rx_er,
  input  logic             frame_start,
  input  logic             byte_done,
  input  logic             frame_end,
  input  logic             odd_pending,
  output logic             err_sticky,
  output logic             eof,
  output logic [LEN_W-1:0] stat_len,
  output logic             stat_err,
  output logic             stat_dribble
);

  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  function automatic logic [LEN_W-1:0] sat_inc(input logic [LEN_W-1:0] v);
    return (v == LEN_MAX) ? v : v + 1'b1;
  endfunction

  logic [LEN_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q      <= '0;
      err_sticky   <= 1'b0;
      eof          <= 1'b0;
      stat_len     <= '0;
      stat_err     <= 1'b0;
      stat_dribble <= 1'b0;
    end else begin
      eof <= frame_end;
      if (frame_start)    count_q <= '0;
      else if (byte_done) count_q <= sat_inc(count_q);
      if (frame_start)             err_sticky <= rx_er;
      else if (rx_dv && rx_er)     err_sticky <= 1'b1;
      if (frame_end) begin
        stat_len     <= count_q;
        stat_err     <= err_sticky;
        stat_dribble <= odd_pending;
      end
    end
  end

endmodule

// File: rtl/mii_rx_assembler.sv
module mii_rx_assembler #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_dv,
  input  logic             rx_er,
  input  logic [3:0]       rxd,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             sof,
  output logic             eof,
  output logic [LEN_W-1:0] stat_len,
  output logic             stat_err,
  output logic             stat_dribble
);

  // internal events, named for the checker
  logic frame_start;
  logic sfd_hit;
  logic data_nib;
  logic frame_end;
  logic byte_done;
  logic odd_pending;
  logic err_sticky;

  mii_rx_delimiter u_delim (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_dv       (rx_dv),
    .rxd         (rxd),
    .frame_start (frame_start),
    .sfd_hit     (sfd_hit),
    .data_nib    (data_nib),
    .frame_end   (frame_end)
  );

  mii_rx_pairer u_pair (
    .clk         (clk),
    .rst_n       (rst_n),
    .sfd_hit     (sfd_hit),
    .data_nib    (data_nib),
    .rxd         (rxd),
    .byte_done   (byte_done),
    .odd_pending (odd_pending),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .sof         (sof)
  );

  mii_rx_status #(.LEN_W(LEN_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_dv        (rx_dv),
    .rx_er        (rx_er),
    .frame_start  (frame_start),
    .byte_done    (byte_done),
    .frame_end    (frame_end),
    .odd_pending  (odd_pending),
    .err_sticky   (err_sticky),
    .eof          (eof),
    .stat_len     (stat_len),
    .stat_err     (stat_err),
    .stat_dribble (stat_dribble)
  );

endmodule

// File: rtl/mii_rx_assembler_chk.sv
module mii_rx_assembler_chk #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_dv,
  input logic             rx_er,
  input logic             byte_valid,
  input logic             sof,
  input logic             eof,
  input logic [LEN_W-1:0] stat_len,
  input logic             stat_err,
  input logic             stat_dribble,
  input logic             frame_start,
  input logic             err_sticky
);

  assert_byte_after_dv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(rx_dv));

  assert_sof_on_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> byte_valid);

  assert_eof_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof);

  assert_eof_after_dv_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> !$past(rx_dv));

  assert_eof_no_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(eof && byte_valid));

  assert_err_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dv && rx_er) |=> err_sticky);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !frame_start) |=> err_sticky);

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !rx_er) |=> !err_sticky);

  assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !eof |-> $stable({stat_len, stat_err, stat_dribble}));

endmodule

bind mii_rx_assembler mii_rx_assembler_chk #(.LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_dv        (rx_dv),
  .rx_er        (rx_er),
  .byte_valid   (byte_valid),
  .sof          (sof),
  .eof          (eof),
  .stat_len     (stat_len),
  .stat_err     (stat_err),
  .stat_dribble (stat_dribble),
  .frame_start  (frame_start),
  .err_sticky   (err_sticky)
);

// File: tb/test_mii_rx_assembler.sv
`timescale 1ns/1ps
module test_mii_rx_assembler;

  localparam int LEN_W   = 11;
  localparam int LEN_CAP = (1 << LEN_W) - 1;
  localparam int NVEC    = 8;
  // preamble nibbles, payload nibbles, first byte, errored nibble index + 1 (0 = none)
  localparam int FRAMES [NVEC][4] = '{
    '{7,  8,  'h10, 0},
    '{1,  2,  'hA0, 0},
    '{15, 9,  'h30, 0},
    '{7,  6,  'h55, 3},
    '{7,  10, 'hD5, 12},
    '{3,  0,  'h00, 0},
    '{2,  1,  'h77, 0},
    '{4,  20, 'hF0, 0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_dv = 1'b0;
  logic             rx_er = 1'b0;
  logic [3:0]       rxd = '0;
  logic             byte_valid;
  logic [7:0]       byte_data;
  logic             sof;
  logic             eof;
  logic [LEN_W-1:0] stat_len;
  logic             stat_err;
  logic             stat_dribble;

  int n_tests = 0;
  int n_fail  = 0;
  logic       cur_bv  = 1'b0;
  logic [7:0] cur_bd  = '0;
  logic       cur_sof = 1'b0;

  always #2.5 clk = ~clk;

  mii_rx_assembler #(.LEN_W(LEN_W)) i_mii_rx_assembler (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
    .byte_valid(byte_valid), .byte_data(byte_data), .sof(sof), .eof(eof),
    .stat_len(stat_len), .stat_err(stat_err), .stat_dribble(stat_dribble)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // check what the previous drive produced, then drive the next cycle
  task automatic step(input logic dv, input logic er, input logic [3:0] nib,
                      input logic ebv, input logic [7:0] ebd, input logic esof);
    @(negedge clk);
    check("R1", "byte_valid", int'(byte_valid), int'(cur_bv));
    if (cur_bv) check("R1", "byte_data", int'(byte_data), int'(cur_bd));
    check("R4", "sof", int'(sof), int'(cur_sof));
    check("R5", "eof idle", int'(eof), 0);
    rx_dv = dv; rx_er = er; rxd = nib;
    cur_bv = ebv; cur_bd = ebd; cur_sof = esof;
  endtask

  task automatic send_frame(input int n_pre, input int n_dat, input int base, input int err_at);
    int k;
    logic [7:0] b;
    logic [3:0] nib;
    int exp_len;
    logic exp_err;
    k = 0;
    for (int i = 0; i < n_pre; i++) begin
      step(1'b1, (k == err_at - 1), 4'h5, 1'b0, 8'h00, 1'b0); k++;
    end
    step(1'b1, (k == err_at - 1), 4'hD, 1'b0, 8'h00, 1'b0); k++;
    for (int j = 0; j < n_dat; j++) begin
      b = 8'(base + j / 2);
      nib = (j % 2 == 0) ? b[3:0] : b[7:4];
      if (j % 2 == 1) step(1'b1, (k == err_at - 1), nib, 1'b1, b, (j == 1));
      else            step(1'b1, (k == err_at - 1), nib, 1'b0, 8'h00, 1'b0);
      k++;
    end
    // rx_er with data-valid low must be ignored (R7)
    step(1'b0, 1'b1, 4'h0, 1'b0, 8'h00, 1'b0);
    exp_len = (n_dat / 2 > LEN_CAP) ? LEN_CAP : n_dat / 2;
    exp_err = (err_at != 0);
    @(negedge clk);
    check("R5", "byte_valid at eof", int'(byte_valid), int'(cur_bv));
    check("R5", "eof", int'(eof), 1);
    check("R6", "stat_len", int'(stat_len), exp_len);
    check("R7", "stat_err", int'(stat_err), int'(exp_err));
    check("R9", "stat_dribble", int'(stat_dribble), n_dat % 2);
    rx_er = 1'b0;
    cur_bv = 1'b0; cur_sof = 1'b0;
  endtask

  task automatic check_status(input string req, input int len, input int err, input int drb);
    check(req, "stat_len", int'(stat_len), len);
    check(req, "stat_err", int'(stat_err), err);
    check(req, "stat_dribble", int'(stat_dribble), drb);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    check("R12", "byte_valid", int'(byte_valid), 0);
    check("R12", "sof", int'(sof), 0);
    check("R12", "eof", int'(eof), 0);
    check_status("R12", 0, 0, 0);
    rst_n = 1'b1;

    // vector table: R1 R2 R4 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++)
      send_frame(FRAMES[v][0], FRAMES[v][1], FRAMES[v][2], FRAMES[v][3]);

    // R11: status held while idle
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0);
    check_status("R11", 10, 0, 0);

    // R3: stray nibble in preamble discards the frame
    step(1'b1, 1'b0, 4'h5, 0, 0, 0);
    step(1'b1, 1'b1, 4'h5, 0, 0, 0);
    step(1'b1, 1'b0, 4'hA, 0, 0, 0);
    step(1'b1, 1'b0, 4'h5, 0, 0, 0);
    step(1'b1, 1'b0, 4'hD, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 4'(i + 1), 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'h0, 0, 0, 0);
    check_status("R3", 10, 0, 0);

    // R3: delimiter with no preamble before it
    step(1'b1, 1'b0, 4'hD, 0, 0, 0);
    step(1'b1, 1'b0, 4'h5, 0, 0, 0);
    step(1'b1, 1'b0, 4'hD, 0, 0, 0);
    step(1'b1, 1'b0, 4'h4, 0, 0, 0);
    step(1'b1, 1'b0, 4'h2, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'h0, 0, 0, 0);
    check_status("R3", 10, 0, 0);

    // R2: minimal frame after discarded one still works, R8 error cleared
    send_frame(1, 4, 'h3C, 0);

    // R10: long frame saturates the byte count
    send_frame(7, 4100, 'h01, 0);
    check_status("R10", LEN_CAP, 0, 0);

    // R12: reset in the middle of a frame clears outputs
    send_frame(2, 6, 'h90, 1);
    step(1'b1, 1'b0, 4'h5, 0, 0, 0);
    step(1'b1, 1'b0, 4'hD, 0, 0, 0);
    step(1'b1, 1'b0, 4'h1, 0, 0, 0);
    step(1'b1, 1'b0, 4'h2, 1, 8'h21, 1);
    @(negedge clk);
    check("R1", "byte before reset", int'(byte_data), 'h21);
    rst_n = 1'b0; rx_dv = 1'b0;
    @(negedge clk);
    check("R12", "byte_valid", int'(byte_valid), 0);
    check("R12", "sof", int'(sof), 0);
    check_status("R12", 0, 0, 0);
    rst_n = 1'b1;
    cur_bv = 1'b0; cur_sof = 1'b0;
    send_frame(3, 5, 'h66, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule